// File: doc/BRIEF.md
# Keypoint Orientation Binner

This block assigns a coarse orientation to an image keypoint. It takes the pixels of a square patch centred on the keypoint as a row-major stream. It accumulates the intensity-weighted first-order moments over a disc inside that patch. From these it forms the angle of the centroid vector and reduces it to one of thirty 12-degree sectors. A descriptor stage downstream uses the sector to pick a rotated set of comparison points.

The angle is found in fixed point. The two moments are folded into the right half-plane and then refined by a fixed number of shift-and-add vector rotations, one per clock. The result is a binary angle, with a full turn equal to 2^16, and a single multiply by 30 turns it into the sector index. Pixels enter through a valid/ready handshake. A beat transfers only in a cycle where both are high, and the source may drop valid at any time. Ready falls after the beat that carries the last marker and stays low while the angle is resolved. It rises again in the cycle where the done strobe is shown.

Top module: `orient_quant`

## Requirements
- R1: A pixel is taken only in a cycle with pix_valid and pix_ready both high. pix_ready is low from the cycle after a beat with pix_last until the cycle in which orient_done is high, and it is high in that cycle.
- R2: The k-th beat of a patch (k from 0) sits at column k mod 31 and row k div 31, giving x = column − 15 and y = row − 15. The beat marked pix_last closes the patch, and its own pixel is included.
- R3: A pixel contributes only when x² + y² ≤ 225. Pixels outside that disc have no effect on the result.
- R4: The block forms the sums Σx·I and Σy·I over the contributing pixels, where I is the 8-bit unsigned pix_data.
- R5: For θ = atan2(Σy·I, Σx·I) taken in [0°, 360°), orient_bin = floor(θ / 12°), which lies between 0 and 29. Bin 0 covers [0°, 12°) and bin 15 covers [180°, 192°).
- R6: When Σy·I is exactly zero, the result is exactly bin 0 if Σx·I > 0 and exactly bin 15 if Σx·I < 0.
- R7: When both sums are zero, as for a uniform patch, orient_bin is 0.
- R8: orient_done is a one-cycle pulse 18 clock edges after the edge that took the last beat. orient_bin changes only in the cycle where orient_done is high, and it holds until the next pulse.
- R9: After reset, pix_ready is 1, orient_done is 0 and orient_bin is 0.
- R10: The first beat of the next patch may be taken in the cycle where orient_done is high. The two patches do not mix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel beat offered |
| pix_ready | output | 1 | Block can take a beat |
| pix_data | input | 8 | Pixel intensity |
| pix_last | input | 1 | Final beat of the patch |
| orient_bin | output | 5 | Orientation sector, 0 to 29 |
| orient_done | output | 1 | One-cycle strobe, result valid |

## Verification
Two events can fall in the same cycle: the result strobe of one patch and the transfer of the first beat of the next. This is because ready comes back exactly when done is shown. The bench provokes this by holding the next patch's first beat valid for the whole busy window while a parallel process waits for the first result. It then judges three things: the beat is taken in the done cycle, the first bin matches an independent model, and the second bin matches a model of its own pixels alone. The bench also closes a patch early with a last beat whose pixel is the only one inside the disc. In that case the final contribution and the freezing of the sums share one edge.

// File: rtl/orient_pkg.sv
package orient_pkg;

  // binary angle: one full turn is 2**ANG_W
  localparam int ANG_W     = 16;
  localparam int NBINS     = 30;
  localparam int BIN_W     = $clog2(NBINS);
  localparam logic [ANG_W-1:0] HALF_TURN = ANG_W'(1) << (ANG_W - 1);

  // arctan(2^-i) in binary-angle units, rounded
  function automatic logic [ANG_W-1:0] atan_step(input int i);
    case (i)
      0:       return 16'd8192;
      1:       return 16'd4836;
      2:       return 16'd2555;
      3:       return 16'd1297;
      4:       return 16'd651;
      5:       return 16'd326;
      6:       return 16'd163;
      7:       return 16'd81;
      8:       return 16'd41;
      9:       return 16'd20;
      10:      return 16'd10;
      11:      return 16'd5;
      12:      return 16'd3;
      13:      return 16'd1;
      14:      return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

  // signed width that holds sum(coord * pixel) over a full square patch
  function automatic int moment_width(input int pix_w, input int half);
    return pix_w + $clog2((2*half+1)*(2*half+1)) + $clog2(half+1) + 1;
  endfunction

endpackage

// File: rtl/oq_moment_acc.sv
module oq_moment_acc #(
  parameter int PIX_W = 8,
  parameter int HALF  = 15,
  parameter int MOM_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_fire,
  input  logic                    in_last,
  input  logic [PIX_W-1:0]        in_pix,
  output logic signed [MOM_W-1:0] m10_o,
  output logic signed [MOM_W-1:0] m01_o,
  output logic                    sums_vld
);

  localparam int PATCH = 2*HALF + 1;
  localparam int CW    = $clog2(PATCH);
  localparam int RW    = CW + 1;          // row counter saturates past the patch
  localparam int SW    = RW + 2;          // signed coordinate width
  localparam int QW    = 2*SW;            // squared radius width
  localparam logic [RW-1:0] ROW_MAX = '1;

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic signed [SW-1:0] crd [2];
  logic signed [QW-1:0] r2;
  logic                 in_disc;
  logic signed [MOM_W-1:0] pv;
  logic signed [MOM_W-1:0] acc     [2];
  logic signed [MOM_W-1:0] acc_nxt [2];

  assign crd[0] = $signed(SW'(col)) - SW'(HALF);
  assign crd[1] = $signed(SW'(row)) - SW'(HALF);

  always_comb begin
    logic signed [QW-1:0] qx, qy;
    qx = QW'(crd[0]);
    qy = QW'(crd[1]);
    r2 = qx*qx + qy*qy;
  end

  assign in_disc = (r2 <= QW'(HALF*HALF));
  assign pv      = $signed(MOM_W'(in_pix));

  // one accumulator per axis
  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic signed [MOM_W-1:0] term;
    assign term       = in_disc ? (pv * MOM_W'(crd[a])) : '0;
    assign acc_nxt[a] = acc[a] + term;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc[a] <= '0;
      end else if (in_fire) begin
        acc[a] <= in_last ? '0 : acc_nxt[a];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col      <= '0;
      row      <= '0;
      m10_o    <= '0;
      m01_o    <= '0;
      sums_vld <= 1'b0;
    end else begin
      sums_vld <= 1'b0;
      if (in_fire) begin
        if (in_last) begin
          col      <= '0;
          row      <= '0;
          m10_o    <= acc_nxt[0];
          m01_o    <= acc_nxt[1];
          sums_vld <= 1'b1;
        end else if (col == CW'(PATCH - 1)) begin
          col <= '0;
          if (row != ROW_MAX) row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/oq_cordic.sv
module oq_cordic
  import orient_pkg::*;
#(
  parameter int MOM_W = 23,
  parameter int ITER  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [MOM_W-1:0] m10,
  input  logic signed [MOM_W-1:0] m01,
  output logic [ANG_W-1:0]        ang,
  output logic                    ang_vld
);

  localparam int XW = MOM_W + 2;          // headroom for fold and gain
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;

  logic signed [XW-1:0] vx, vy, vx_n, vy_n, mx, my;
  logic [ANG_W-1:0]     vz, vz_n, axis_z;
  logic [IW-1:0]        it;
  logic                 run, on_axis;

  assign mx = XW'(m10);
  assign my = XW'(m01);

  // one vectoring micro-rotation, driving vy toward zero
  always_comb begin
    logic signed [XW-1:0] sx, sy;
    sx = vx >>> it;
    sy = vy >>> it;
    if (vy >= 0) begin
      vx_n = vx + sy;
      vy_n = vy - sx;
      vz_n = vz + atan_step(int'(it));
    end else begin
      vx_n = vx - sy;
      vy_n = vy + sx;
      vz_n = vz - atan_step(int'(it));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vx      <= '0;
      vy      <= '0;
      vz      <= '0;
      it      <= '0;
      run     <= 1'b0;
      on_axis <= 1'b0;
      axis_z  <= '0;
      ang     <= '0;
      ang_vld <= 1'b0;
    end else begin
      ang_vld <= 1'b0;
      if (start) begin
        // fold the left half-plane over by half a turn
        if (mx < 0) begin
          vx <= -mx;
          vy <= -my;
          vz <= HALF_TURN;
        end else begin
          vx <= mx;
          vy <= my;
          vz <= '0;
        end
        on_axis <= (my == 0);
        axis_z  <= (mx < 0) ? HALF_TURN : '0;
        it      <= '0;
        run     <= 1'b1;
      end else if (run) begin
        vx <= vx_n;
        vy <= vy_n;
        vz <= vz_n;
        if (it == IW'(ITER - 1)) begin
          run     <= 1'b0;
          ang_vld <= 1'b1;
          ang     <= on_axis ? axis_z : vz_n;
        end else begin
          it <= it + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/oq_binner.sv
module oq_binner
  import orient_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ang_vld,
  input  logic [ANG_W-1:0]   ang,
  output logic [BIN_W-1:0]   bin,
  output logic               done
);

  localparam int PW = ANG_W + BIN_W;

  logic [PW-1:0] prod;

  // floor(ang * NBINS / 2**ANG_W)
  assign prod = PW'(ang) * PW'(NBINS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin  <= '0;
      done <= 1'b0;
    end else begin
      done <= ang_vld;
      if (ang_vld) bin <= BIN_W'(prod >> ANG_W);
    end
  end

endmodule

// File: rtl/orient_quant.sv
module orient_quant
  import orient_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int HALF  = 15,
  parameter int ITER  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [PIX_W-1:0]   pix_data,
  input  logic               pix_last,
  output logic [BIN_W-1:0]   orient_bin,
  output logic               orient_done
);

  localparam int MOM_W = moment_width(PIX_W, HALF);

  logic                    busy, fire, sums_vld, ang_vld;
  logic signed [MOM_W-1:0] m10, m01;
  logic [ANG_W-1:0]        ang;

  assign pix_ready = !busy;
  assign fire      = pix_valid && pix_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)                busy <= 1'b0;
    else if (fire && pix_last) busy <= 1'b1;
    else if (ang_vld)          busy <= 1'b0;
  end

  oq_moment_acc #(.PIX_W(PIX_W), .HALF(HALF), .MOM_W(MOM_W)) u_mom (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (fire),
    .in_last  (pix_last),
    .in_pix   (pix_data),
    .m10_o    (m10),
    .m01_o    (m01),
    .sums_vld (sums_vld)
  );

  oq_cordic #(.MOM_W(MOM_W), .ITER(ITER)) u_rot (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sums_vld),
    .m10     (m10),
    .m01     (m01),
    .ang     (ang),
    .ang_vld (ang_vld)
  );

  oq_binner u_bin (
    .clk     (clk),
    .rst_n   (rst_n),
    .ang_vld (ang_vld),
    .ang     (ang),
    .bin     (orient_bin),
    .done    (orient_done)
  );

endmodule

// File: rtl/oq_checker.sv
module oq_checker
  import orient_pkg::*;
#(
  parameter int LAT = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             pix_last,
  input logic [BIN_W-1:0] orient_bin,
  input logic             orient_done
);

  logic        armed;
  logic [15:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      since <= '0;
    end else if (pix_valid && pix_ready && pix_last) begin
      armed <= 1'b1;
      since <= '0;
    end else if (orient_done) begin
      armed <= 1'b0;
    end else if (armed && since != 16'hFFFF) begin
      since <= since + 1'b1;
    end
  end

  // R1: no transfer while an angle is being resolved
  a_r1_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !orient_done) |-> !pix_ready);

  // R1 / R10: ready returns together with the strobe
  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    orient_done |-> pix_ready);

  // R8: strobe arrives a fixed number of edges after the last beat
  a_r8_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    orient_done |-> (armed && since == 16'(LAT)));

  // R8: strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    orient_done |=> !orient_done);

  // R8: sector only moves with the strobe
  a_r8_bin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !orient_done |-> $stable(orient_bin));

  // R5: sector index in range
  a_r5_bin_range: assert property (@(posedge clk) disable iff (!rst_n)
    orient_bin < BIN_W'(NBINS));

endmodule

bind orient_quant oq_checker #(.LAT(ITER + 2)) u_oq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_valid   (pix_valid),
  .pix_ready   (pix_ready),
  .pix_last    (pix_last),
  .orient_bin  (orient_bin),
  .orient_done (orient_done)
);

// File: tb/orient_quant_bench.sv
module orient_quant_bench;

  localparam int LAT = 18;
  localparam int P   = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_data = '0;
  logic       pix_last = 1'b0;
  logic [4:0] orient_bin;
  logic       orient_done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_acc_cyc = 0;
  int img  [2][P][P];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  orient_quant u_orient_quant (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_last(pix_last),
    .orient_bin(orient_bin), .orient_done(orient_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sector_of(input real t);
    real w;
    w = t;
    if (w < 0.0) w = w + 360.0;
    if (w >= 360.0) w = w - 360.0;
    return int'($floor(w / 12.0)) % 30;
  endfunction

  task automatic clear_img(input int w);
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) img[w][r][c] = 0;
  endtask

  task automatic put(input int w, input int x, input int y, input int v);
    img[w][y+15][x+15] = v;
  endtask

  task automatic push(input int v, input bit lst, input bit gap);
    if (gap) begin
      @(negedge clk);
      pix_valid = 1'b0;
    end
    @(negedge clk);
    pix_valid = 1'b1;
    pix_data  = v[7:0];
    pix_last  = lst;
    while (!pix_ready) @(negedge clk);
    @(posedge clk);
    #1;
    last_acc_cyc = cyc;
  endtask

  // streams the first n pixels of image w; model of R2-R7 gives the allowed bins
  task automatic send_patch(input int w, input int n, input bit gaps,
                            output int e_lo, output int e_hi);
    longint s10, s01;
    real th;
    s10 = 0;
    s01 = 0;
    for (int k = 0; k < n; k++) begin
      int r, c, x, y;
      r = k / P;
      c = k % P;
      x = c - 15;
      y = r - 15;
      if (x*x + y*y <= 225) begin
        s10 += longint'(x * img[w][r][c]);
        s01 += longint'(y * img[w][r][c]);
      end
      push(img[w][r][c], k == n-1, gaps && (k % 3 == 2));
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_last  = 1'b0;
    if (s01 == 0) begin
      e_lo = (s10 < 0) ? 15 : 0;
      e_hi = e_lo;
    end else begin
      th = $atan2(real'(s01), real'(s10)) * 180.0 / 3.14159265358979;
      e_lo = sector_of(th - 0.05);
      e_hi = sector_of(th + 0.05);
    end
  endtask

  task automatic wait_result(input string tag, input int n0, input int e_lo, input int e_hi);
    int spent;
    spent = 0;
    while (!orient_done && spent < 1000) begin
      @(negedge clk);
      spent++;
    end
    check(orient_done, {tag, " R8 strobe seen"}, int'(orient_done), 1);
    check(cyc - n0 == LAT, {tag, " R8 latency"}, cyc - n0, LAT);
    check(orient_bin == 5'(e_lo) || orient_bin == 5'(e_hi), {tag, " R5 sector"},
          int'(orient_bin), e_lo);
    check(pix_ready, {tag, " R1 ready with strobe"}, int'(pix_ready), 1);
    @(negedge clk);
    check(!orient_done, {tag, " R8 single pulse"}, int'(orient_done), 0);
  endtask

  task automatic run_full(input string tag, input bit gaps);
    int lo, hi;
    send_patch(0, P*P, gaps, lo, hi);
    wait_result(tag, last_acc_cyc, lo, hi);
  endtask

  task automatic test_reset();
    check(pix_ready == 1'b1, "R9 ready after reset", int'(pix_ready), 1);
    check(orient_done == 1'b0, "R9 done after reset", int'(orient_done), 0);
    check(orient_bin == 5'd0, "R9 bin after reset", int'(orient_bin), 0);
  endtask

  task automatic test_uniform();
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) img[0][r][c] = 90;
    run_full("R7 uniform", 1'b0);
  endtask

  task automatic test_point(input int x, input int y, input string tag);
    clear_img(0);
    put(0, x, y, 200);
    run_full(tag, 1'b0);
  endtask

  task automatic test_gradients();
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) img[0][r][c] = 50 + (c-15) + 2*(r-15);
    run_full("R4 ramp up-right", 1'b0);
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) img[0][r][c] = 128 - 3*(c-15) + (r-15);
    run_full("R4 ramp left gaps", 1'b1);
  endtask

  task automatic test_mask();
    clear_img(0);
    put(0, -11, -11, 255);
    put(0, 0, 3, 10);
    run_full("R3 outside corner ignored", 1'b0);
    check(orient_bin == 5'd7, "R3 outside bin", int'(orient_bin), 7);
    clear_img(0);
    put(0, -15, 0, 200);
    put(0, 2, -2, 100);
    run_full("R3 rim included", 1'b0);
    check(orient_bin == 5'd15, "R3 rim bin", int'(orient_bin), 15);
  endtask

  task automatic test_early_last();
    int lo, hi;
    clear_img(0);
    put(0, 4, -1, 220);
    put(0, -8, 5, 255);
    send_patch(0, 14*P + 20, 1'b0, lo, hi);
    wait_result("R2 early last", last_acc_cyc, lo, hi);
    check(orient_bin == 5'd28, "R2 last beat counted", int'(orient_bin), 28);
  endtask

  task automatic test_back_to_back();
    int alo, ahi, blo, bhi, na, taken;
    clear_img(0);
    put(0, 3, 4, 200);
    clear_img(1);
    put(1, -7, 2, 150);
    send_patch(0, P*P, 1'b0, alo, ahi);
    na = last_acc_cyc;
    taken = -1;
    fork
      wait_result("R10 first patch", na, alo, ahi);
      begin
        push(img[1][0][0], 1'b0, 1'b0);
        taken = last_acc_cyc;
      end
    join
    check(taken == na + LAT + 1, "R10 first beat taken in strobe cycle", taken, na + LAT + 1);
    begin
      int lo, hi;
      for (int k = 1; k < P*P; k++)
        push(img[1][k / P][k % P], k == P*P-1, 1'b0);
      @(negedge clk);
      pix_valid = 1'b0;
      pix_last  = 1'b0;
      lo = sector_of(164.05 - 0.05);
      hi = sector_of(164.05 + 0.05);
      wait_result("R10 second patch", last_acc_cyc, lo, hi);
      check(orient_bin == 5'd13, "R10 second bin", int'(orient_bin), 13);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_uniform();
    test_point(5, 0, "R6 pos axis");
    check(orient_bin == 5'd0, "R6 pos axis bin", int'(orient_bin), 0);
    test_point(-5, 0, "R6 neg axis");
    check(orient_bin == 5'd15, "R6 neg axis bin", int'(orient_bin), 15);
    test_point(3, 4, "R5 first quadrant");
    test_point(0, -9, "R5 straight up");
    test_point(10, -1, "R5 near wrap");
    test_point(0, 5, "R5 straight down");
    test_gradients();
    test_mask();
    test_early_last();
    test_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule